// File: doc/BRIEF.md
# Banked L1 Access Latency Pipeline

This block sits between the issue stage of a load/store unit and the tag lookup of a level-one data cache. One instruction's pending memory accesses are loaded into a small queue in a single step. From then on the block drains that queue from its back end. Each access is steered to a bank by its address and dropped into the tail of that bank's fixed-latency delay line. In each cycle the block issues at most one access per bank. It stops trying as soon as a bank's tail slot is taken.

Each delay line is a chain of slots that closes up bubbles. The head slot offers its request to the cache lookup port of its bank and receives one of four results in the same cycle. A reservation failure keeps the request at the head so that it is tried again. The other three results free the head, and a retire pulse marks the cycle in which that happens. The block tells the issue stage whether the queue is empty and why it is stalling. When stores are issued, it also reports how far the outstanding store-acknowledge count must rise.

Top module: `l1BankedLatency`

## Requirements
- R1: With SECTOR_MODE=1 an access goes to bank ((addr >> log2(SECTOR_BYTES)) & (NBANKS-1)).
- R2: With SECTOR_MODE=0 an access goes to bank ((addr >> log2(LINE_BYTES)) & (NBANKS-1)), so two accesses in one line use the same bank.
- R3: The queue is loaded with entries 0..loadCount-1. Accesses leave it from the highest index downward, with at most NBANKS attempts per cycle and at most one access written per bank per cycle.
- R4: An access is written into its bank's tail slot only if that slot was empty at the start of the cycle. If the slot was taken, or was already claimed in this cycle, stallCode is 1 (bank conflict), the access stays queued, and nothing more is tried in that cycle.
- R5: stallCode is 2 (coalescing stall) when accesses remain queued after a cycle with no conflict. It is 0 when the queue drains in this cycle or is empty.
- R6: An access issued in cycle t into an empty line is presented at that bank's head (lookupValid high, lookupAddr equal to its address) in cycle t+LATENCY.
- R7: lookupResult per bank is 2 bits: 0 hit, 1 miss, 2 hit-reserved, 3 reservation fail. Codes 0 to 2 pulse retire and free the head at the next edge. Code 3 keeps the same request at the head.
- R8: In each line, every request behind the first empty slot moves one slot toward the head per cycle. A request behind a held head waits in the nearest free slot and reaches the head in the cycle after the head retires.
- R9: In the issue cycle, ackInc equals the sum over the stores being issued of (size / SECTOR_BYTES) when SECTOR_MODE=1, and of 1 per store when SECTOR_MODE=0. Loads add nothing.
- R10: A load request is taken only when queueEmpty is high. A load request offered while the queue is not empty is ignored.
- R11: After reset, queueEmpty is 1, stallCode is 0, and lookupValid, retire and ackInc are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadValid | input | 1 | Offer a new instruction's access list |
| loadCount | input | CNT_W | Number of accesses in the offered list |
| loadAddr | input | QDEPTH*ADDR_W | Byte address of each entry, entry i at bits [i*ADDR_W +: ADDR_W] |
| loadStore | input | QDEPTH | Entry is a store |
| loadSize | input | QDEPTH*SIZE_W | Data size of each entry in bytes |
| queueEmpty | output | 1 | No access is pending |
| stallCode | output | 2 | 0 none, 1 bank conflict, 2 coalescing stall |
| lookupValid | output | NBANKS | Head slot of each bank holds a request |
| lookupAddr | output | NBANKS*ADDR_W | Address at each bank's head |
| lookupStore | output | NBANKS | Head request is a store |
| lookupResult | input | 2*NBANKS | Lookup result per bank, same cycle |
| retire | output | NBANKS | Head request leaves its line at the next edge |
| ackInc | output | ACK_W | Store-acknowledge increment for this cycle |

## Verification
The bench builds two instances. The first has four banks, a three-slot line and sector steering with 32-byte sectors. This depth lets a request wait in a middle slot behind a held head, and it lets a five-entry list show a coalescing stall, then a conflict, then a clean issue. The second has two banks, a single-slot line and 128-byte line steering. It shows that addresses in one sector-distinct pair collide in the same line. It also shows that a one-slot line conflicts in the very cycle its head retires, and that a store adds one acknowledgement whatever its size.

// File: rtl/l1lat_pkg.sv
package l1lat_pkg;

  typedef enum logic [1:0] {
    LK_HIT      = 2'd0,
    LK_MISS     = 2'd1,
    LK_HIT_RSV  = 2'd2,
    LK_RSV_FAIL = 2'd3
  } lkResult_e;

  typedef enum logic [1:0] {
    STALL_NONE = 2'd0,
    STALL_BANK = 2'd1,
    STALL_COAL = 2'd2
  } stall_e;

  // strobes from issue control to the datapath
  typedef struct packed {
    logic   loadTake;
    stall_e stall;
  } issueStrb_t;

endpackage

// File: rtl/l1BankLine.sv
module l1BankLine
  import l1lat_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LATENCY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrStore,
  input  lkResult_e         headResult,
  output logic              tailBusy,
  output logic              headValid,
  output logic [ADDR_W-1:0] headAddr,
  output logic              headStore,
  output logic              retire
);

  logic [LATENCY-1:0] slotV, nV;
  logic [ADDR_W-1:0]  slotA [LATENCY];
  logic [ADDR_W-1:0]  nA    [LATENCY];
  logic               slotS [LATENCY];
  logic               nS    [LATENCY];

  assign headValid = slotV[0];
  assign headAddr  = slotA[0];
  assign headStore = slotS[0];
  assign tailBusy  = slotV[LATENCY-1];
  assign retire    = slotV[0] && (headResult != LK_RSV_FAIL);

  always_comb begin
    nV = slotV;
    for (int s = 0; s < LATENCY; s++) begin
      nA[s] = slotA[s];
      nS[s] = slotS[s];
    end
    if (retire) nV[0] = 1'b0;
    // close bubbles: each empty stage pulls from the one behind it
    for (int s = 0; s < LATENCY - 1; s++) begin
      if (!nV[s]) begin
        nV[s]   = nV[s+1];
        nA[s]   = nA[s+1];
        nS[s]   = nS[s+1];
        nV[s+1] = 1'b0;
      end
    end
    if (wrEn) begin
      nV[LATENCY-1] = 1'b1;
      nA[LATENCY-1] = wrAddr;
      nS[LATENCY-1] = wrStore;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotV <= '0;
      for (int s = 0; s < LATENCY; s++) begin
        slotA[s] <= '0;
        slotS[s] <= 1'b0;
      end
    end else begin
      slotV <= nV;
      for (int s = 0; s < LATENCY; s++) begin
        slotA[s] <= nA[s];
        slotS[s] <= nS[s];
      end
    end
  end

  // R4: issue only lands in a tail that was free
  a_r4_tail_free: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !tailBusy);

  // R7: a failed reservation keeps the same request at the head
  a_r7_rsvfail_hold: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && headResult == LK_RSV_FAIL) |=> (headValid && headAddr == $past(headAddr)));

  // R8: collapsing never loses or invents a request
  a_r8_occupancy: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(slotV) ==
              $countones($past(slotV)) + int'($past(wrEn)) - int'($past(retire))));

endmodule

// File: rtl/l1IssueCtrl.sv
module l1IssueCtrl
  import l1lat_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int NBANKS       = 1,
  parameter int QDEPTH       = 8,
  parameter int SECTOR_MODE  = 1,
  parameter int SECTOR_BYTES = 32,
  parameter int LINE_BYTES   = 128,
  localparam int CNT_W  = $clog2(QDEPTH + 1),
  localparam int SEL_W  = (NBANKS > 1) ? $clog2(NBANKS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadValid,
  input  logic [CNT_W-1:0]         qCount,
  input  logic [NBANKS*ADDR_W-1:0] backAddrFlat,
  input  logic [NBANKS-1:0]        tailBusy,
  output issueStrb_t               strb,
  output logic [CNT_W-1:0]         popCnt,
  output logic [NBANKS-1:0]        bankWr,
  output logic [NBANKS*SEL_W-1:0]  bankSelFlat
);

  localparam int SHIFT = (SECTOR_MODE != 0) ? $clog2(SECTOR_BYTES) : $clog2(LINE_BYTES);

  function automatic logic [SEL_W-1:0] bankOf(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] sh;
    sh = a >> SHIFT;
    return sh[SEL_W-1:0] & SEL_W'(NBANKS - 1);
  endfunction

  logic             conflict;
  logic             stop;
  logic [SEL_W-1:0] bk;
  logic [CNT_W-1:0] remaining;

  // walk the back of the queue, one candidate per possible bank
  always_comb begin
    bankWr      = '0;
    bankSelFlat = '0;
    popCnt      = '0;
    conflict    = 1'b0;
    stop        = 1'b0;
    bk          = '0;
    for (int j = 0; j < NBANKS; j++) begin
      if (!stop && (j < int'(qCount))) begin
        bk = bankOf(backAddrFlat[j*ADDR_W +: ADDR_W]);
        if (tailBusy[bk] || bankWr[bk]) begin
          conflict = 1'b1;
          stop     = 1'b1;
        end else begin
          bankWr[bk] = 1'b1;
          bankSelFlat[int'(bk)*SEL_W +: SEL_W] = SEL_W'(j);
          popCnt = popCnt + CNT_W'(1);
        end
      end
    end
  end

  assign remaining     = qCount - popCnt;
  assign strb.loadTake = loadValid && (qCount == '0);
  assign strb.stall    = conflict ? STALL_BANK
                       : (remaining != '0) ? STALL_COAL : STALL_NONE;

  // R5: an empty queue never reports a stall
  a_r5_empty_no_stall: assert property (@(posedge clk) disable iff (!rstN)
    (qCount == '0) |-> (strb.stall == STALL_NONE));

  // R3: one write per issued access, never more than pending
  a_r3_pop_bound: assert property (@(posedge clk) disable iff (!rstN)
    (popCnt <= qCount) && ($countones(bankWr) == int'(popCnt)));

endmodule

// File: rtl/l1AccessDatapath.sv
module l1AccessDatapath
  import l1lat_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 8,
  parameter int NBANKS       = 1,
  parameter int QDEPTH       = 8,
  parameter int LATENCY      = 1,
  parameter int SECTOR_MODE  = 1,
  parameter int SECTOR_BYTES = 32,
  localparam int CNT_W = $clog2(QDEPTH + 1),
  localparam int SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int ACK_W = SIZE_W + SEL_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [CNT_W-1:0]         loadCount,
  input  logic [QDEPTH*ADDR_W-1:0] loadAddrFlat,
  input  logic [QDEPTH-1:0]        loadStoreVec,
  input  logic [QDEPTH*SIZE_W-1:0] loadSizeFlat,
  input  issueStrb_t               strb,
  input  logic [CNT_W-1:0]         popCnt,
  input  logic [NBANKS-1:0]        bankWr,
  input  logic [NBANKS*SEL_W-1:0]  bankSelFlat,
  input  logic [2*NBANKS-1:0]      lookupResultFlat,
  output logic [CNT_W-1:0]         qCount,
  output logic [NBANKS*ADDR_W-1:0] backAddrFlat,
  output logic [NBANKS-1:0]        tailBusy,
  output logic [NBANKS-1:0]        lookupValid,
  output logic [NBANKS*ADDR_W-1:0] lookupAddrFlat,
  output logic [NBANKS-1:0]        lookupStore,
  output logic [NBANKS-1:0]        retire,
  output logic [ACK_W-1:0]         ackInc
);

  localparam int SEC_SHIFT = $clog2(SECTOR_BYTES);

  logic [ADDR_W-1:0] qAddr  [QDEPTH];
  logic              qStore [QDEPTH];
  logic [SIZE_W-1:0] qSize  [QDEPTH];

  logic [ADDR_W-1:0] wrAddr  [NBANKS];
  logic              wrStore [NBANKS];
  logic [SIZE_W-1:0] wrSize  [NBANKS];

  // pending-access queue
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qCount <= '0;
      for (int i = 0; i < QDEPTH; i++) begin
        qAddr[i]  <= '0;
        qStore[i] <= 1'b0;
        qSize[i]  <= '0;
      end
    end else if (strb.loadTake) begin
      qCount <= (int'(loadCount) > QDEPTH) ? CNT_W'(QDEPTH) : loadCount;
      for (int i = 0; i < QDEPTH; i++) begin
        qAddr[i]  <= loadAddrFlat[i*ADDR_W +: ADDR_W];
        qStore[i] <= loadStoreVec[i];
        qSize[i]  <= loadSizeFlat[i*SIZE_W +: SIZE_W];
      end
    end else begin
      qCount <= qCount - popCnt;
    end
  end

  // candidates seen by control, back entry first
  always_comb begin
    backAddrFlat = '0;
    for (int j = 0; j < NBANKS; j++) begin
      if (j < int'(qCount)) backAddrFlat[j*ADDR_W +: ADDR_W] = qAddr[int'(qCount) - 1 - j];
    end
  end

  // per-bank write data selected by the control's strobes
  always_comb begin
    int ix;
    ix = 0;
    for (int b = 0; b < NBANKS; b++) begin
      wrAddr[b]  = '0;
      wrStore[b] = 1'b0;
      wrSize[b]  = '0;
      if (bankWr[b]) begin
        ix = int'(qCount) - 1 - int'(bankSelFlat[b*SEL_W +: SEL_W]);
        if (ix >= 0) begin
          wrAddr[b]  = qAddr[ix];
          wrStore[b] = qStore[ix];
          wrSize[b]  = qSize[ix];
        end
      end
    end
  end

  always_comb begin
    ackInc = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bankWr[b] && wrStore[b]) begin
        if (SECTOR_MODE != 0) ackInc = ackInc + ACK_W'(wrSize[b] >> SEC_SHIFT);
        else                  ackInc = ackInc + ACK_W'(1);
      end
    end
  end

  for (genvar b = 0; b < NBANKS; b++) begin : gBank
    l1BankLine #(
      .ADDR_W (ADDR_W),
      .LATENCY(LATENCY)
    ) uLine (
      .clk       (clk),
      .rstN      (rstN),
      .wrEn      (bankWr[b]),
      .wrAddr    (wrAddr[b]),
      .wrStore   (wrStore[b]),
      .headResult(lkResult_e'(lookupResultFlat[2*b +: 2])),
      .tailBusy  (tailBusy[b]),
      .headValid (lookupValid[b]),
      .headAddr  (lookupAddrFlat[b*ADDR_W +: ADDR_W]),
      .headStore (lookupStore[b]),
      .retire    (retire[b])
    );
  end

  // R10: outside a load the count only falls by what was issued
  a_r10_count_drop: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadTake |=> (qCount == $past(qCount) - $past(popCnt)));

  // R10: a load is only taken into an empty queue
  a_r10_load_empty: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadTake |-> (qCount == '0));

endmodule

// File: rtl/l1BankedLatency.sv
module l1BankedLatency
  import l1lat_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int SIZE_W       = 8,
  parameter int NBANKS       = 1,
  parameter int LATENCY      = 1,
  parameter int QDEPTH       = 8,
  parameter int SECTOR_MODE  = 1,
  parameter int SECTOR_BYTES = 32,
  parameter int LINE_BYTES   = 128,
  localparam int CNT_W = $clog2(QDEPTH + 1),
  localparam int SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1,
  localparam int ACK_W = SIZE_W + SEL_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     loadValid,
  input  logic [CNT_W-1:0]         loadCount,
  input  logic [QDEPTH*ADDR_W-1:0] loadAddr,
  input  logic [QDEPTH-1:0]        loadStore,
  input  logic [QDEPTH*SIZE_W-1:0] loadSize,
  output logic                     queueEmpty,
  output logic [1:0]               stallCode,
  output logic [NBANKS-1:0]        lookupValid,
  output logic [NBANKS*ADDR_W-1:0] lookupAddr,
  output logic [NBANKS-1:0]        lookupStore,
  input  logic [2*NBANKS-1:0]      lookupResult,
  output logic [NBANKS-1:0]        retire,
  output logic [ACK_W-1:0]         ackInc
);

  issueStrb_t              strb;
  logic [CNT_W-1:0]        qCount;
  logic [CNT_W-1:0]        popCnt;
  logic [NBANKS-1:0]       bankWr;
  logic [NBANKS*SEL_W-1:0] bankSel;
  logic [NBANKS*ADDR_W-1:0] backAddr;
  logic [NBANKS-1:0]       tailBusy;

  l1IssueCtrl #(
    .ADDR_W      (ADDR_W),
    .NBANKS      (NBANKS),
    .QDEPTH      (QDEPTH),
    .SECTOR_MODE (SECTOR_MODE),
    .SECTOR_BYTES(SECTOR_BYTES),
    .LINE_BYTES  (LINE_BYTES)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .loadValid   (loadValid),
    .qCount      (qCount),
    .backAddrFlat(backAddr),
    .tailBusy    (tailBusy),
    .strb        (strb),
    .popCnt      (popCnt),
    .bankWr      (bankWr),
    .bankSelFlat (bankSel)
  );

  l1AccessDatapath #(
    .ADDR_W      (ADDR_W),
    .SIZE_W      (SIZE_W),
    .NBANKS      (NBANKS),
    .QDEPTH      (QDEPTH),
    .LATENCY     (LATENCY),
    .SECTOR_MODE (SECTOR_MODE),
    .SECTOR_BYTES(SECTOR_BYTES)
  ) uData (
    .clk             (clk),
    .rstN            (rstN),
    .loadCount       (loadCount),
    .loadAddrFlat    (loadAddr),
    .loadStoreVec    (loadStore),
    .loadSizeFlat    (loadSize),
    .strb            (strb),
    .popCnt          (popCnt),
    .bankWr          (bankWr),
    .bankSelFlat     (bankSel),
    .lookupResultFlat(lookupResult),
    .qCount          (qCount),
    .backAddrFlat    (backAddr),
    .tailBusy        (tailBusy),
    .lookupValid     (lookupValid),
    .lookupAddrFlat  (lookupAddr),
    .lookupStore     (lookupStore),
    .retire          (retire),
    .ackInc          (ackInc)
  );

  assign queueEmpty = (qCount == '0);
  assign stallCode  = strb.stall;

endmodule

// File: tb/tb_l1BankedLatency.sv
`timescale 1ns/1ps
module tb_l1BankedLatency;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  // main instance: 4 banks, 3 slots, sector steering
  logic         loadValid = 1'b0;
  logic [3:0]   loadCount = '0;
  logic [255:0] loadAddr  = '0;
  logic [7:0]   loadStore = '0;
  logic [63:0]  loadSize  = '0;
  logic         queueEmpty;
  logic [1:0]   stallCode;
  logic [3:0]   lookupValid;
  logic [127:0] lookupAddr;
  logic [3:0]   lookupStore;
  logic [7:0]   lkRes = '0;
  logic [3:0]   retire;
  logic [10:0]  ackInc;

  l1BankedLatency #(.NBANKS(4), .LATENCY(3), .SECTOR_MODE(1)) dut (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadCount(loadCount),
    .loadAddr(loadAddr), .loadStore(loadStore), .loadSize(loadSize),
    .queueEmpty(queueEmpty), .stallCode(stallCode), .lookupValid(lookupValid),
    .lookupAddr(lookupAddr), .lookupStore(lookupStore), .lookupResult(lkRes),
    .retire(retire), .ackInc(ackInc));

  // second instance: 2 banks, 1 slot, line steering
  logic         lnLoadValid = 1'b0;
  logic [3:0]   lnLoadCount = '0;
  logic [255:0] lnLoadAddr  = '0;
  logic [7:0]   lnLoadStore = '0;
  logic [63:0]  lnLoadSize  = '0;
  logic         lnEmpty;
  logic [1:0]   lnStall;
  logic [1:0]   lnValid;
  logic [63:0]  lnAddr;
  logic [1:0]   lnStore;
  logic [1:0]   lnRetire;
  logic [9:0]   lnAck;

  l1BankedLatency #(.NBANKS(2), .LATENCY(1), .SECTOR_MODE(0), .LINE_BYTES(128)) dutLine (
    .clk(clk), .rstN(rstN), .loadValid(lnLoadValid), .loadCount(lnLoadCount),
    .loadAddr(lnLoadAddr), .loadStore(lnLoadStore), .loadSize(lnLoadSize),
    .queueEmpty(lnEmpty), .stallCode(lnStall), .lookupValid(lnValid),
    .lookupAddr(lnAddr), .lookupStore(lnStore), .lookupResult(4'b0000),
    .retire(lnRetire), .ackInc(lnAck));

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expQ [4][$];
  logic [31:0] tbA [8];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic setEntry(input int i, input logic [31:0] a, input bit st, input logic [7:0] sz);
    tbA[i] = a;
    loadAddr[i*32 +: 32] = a;
    loadStore[i] = st;
    loadSize[i*8 +: 8] = sz;
  endtask

  // caller sits at a negedge; returns at the negedge of the issue cycle
  task automatic doLoad(input int n);
    loadCount = 4'(n);
    loadValid = 1'b1;
    for (int i = n - 1; i >= 0; i--) expQ[(tbA[i] >> 5) & 3].push_back(tbA[i]);
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic setLine(input int i, input logic [31:0] a, input bit st, input logic [7:0] sz);
    lnLoadAddr[i*32 +: 32] = a;
    lnLoadStore[i] = st;
    lnLoadSize[i*8 +: 8] = sz;
  endtask

  task automatic doLoadLine(input int n);
    lnLoadCount = 4'(n);
    lnLoadValid = 1'b1;
    @(negedge clk);
    lnLoadValid = 1'b0;
  endtask

  // scoreboard monitor: each retire must match the oldest expected request of its bank
  always @(negedge clk) begin
    if (rstN) begin
      for (int b = 0; b < 4; b++) begin
        if (retire[b]) begin
          if (expQ[b].size() == 0) begin
            check(1'b0, "R10 unexpected retire", lookupAddr[b*32 +: 32], 0);
          end else begin
            logic [31:0] e;
            e = expQ[b].pop_front();
            check(lookupAddr[b*32 +: 32] == e, "R7 retire order", lookupAddr[b*32 +: 32], e);
          end
        end
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(queueEmpty == 1'b1, "R11 queueEmpty", queueEmpty, 1);
    check(stallCode == 2'd0, "R11 stallCode", stallCode, 0);
    check(lookupValid == 4'h0 && retire == 4'h0, "R11 lookupValid", lookupValid, 0);
    check(ackInc == '0, "R11 ackInc", ackInc, 0);

    // four sectors to four banks; bank2 misses, bank3 hit-reserved
    lkRes = 8'b10_01_00_00;
    setEntry(0, 32'h000, 0, 32); setEntry(1, 32'h020, 0, 32);
    setEntry(2, 32'h040, 0, 32); setEntry(3, 32'h060, 0, 32);
    doLoad(4);
    check(stallCode == 2'd0, "R5 drained in one cycle", stallCode, 0);
    check(queueEmpty == 1'b0, "R10 loaded", queueEmpty, 0);
    check(ackInc == '0, "R9 loads add nothing", ackInc, 0);
    @(negedge clk);
    check(queueEmpty == 1'b1, "R3 four banks in one cycle", queueEmpty, 1);
    check(lookupValid == 4'h0, "R6 not yet at head", lookupValid, 0);
    @(negedge clk);
    check(lookupValid == 4'h0, "R6 not yet at head", lookupValid, 0);
    @(negedge clk);
    check(lookupValid == 4'hF, "R1 R6 head after LATENCY", lookupValid, 4'hF);
    repeat (3) @(negedge clk);
    lkRes = '0;

    // two in bank0: conflict on same bank in one cycle, then busy tail
    setEntry(0, 32'h100, 0, 32); setEntry(1, 32'h020, 0, 32); setEntry(2, 32'h080, 0, 32);
    doLoad(3);
    check(stallCode == 2'd1, "R4 same-cycle bank claim", stallCode, 1);
    check(queueEmpty == 1'b0, "R4 access stays queued", queueEmpty, 0);
    @(negedge clk);
    check(stallCode == 2'd1, "R4 tail busy", stallCode, 1);
    // offer a load while not empty: must be ignored
    loadAddr[31:0] = 32'h3E0;
    loadCount = 4'd1;
    loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
    check(stallCode == 2'd0, "R4 tail freed by shift", stallCode, 0);
    @(negedge clk);
    check(queueEmpty == 1'b1, "R10 ignored load", queueEmpty, 1);
    @(negedge clk);
    check(queueEmpty == 1'b1, "R10 ignored load stays out", queueEmpty, 1);
    repeat (6) @(negedge clk);

    // five entries: coalescing stall, then conflict, then clean
    setEntry(0, 32'h200, 0, 32); setEntry(1, 32'h220, 0, 32); setEntry(2, 32'h240, 0, 32);
    setEntry(3, 32'h260, 0, 32); setEntry(4, 32'h280, 0, 32);
    doLoad(5);
    check(stallCode == 2'd2, "R5 coalescing stall", stallCode, 2);
    @(negedge clk);
    check(stallCode == 2'd1, "R3 R4 leftover hits busy tail", stallCode, 1);
    @(negedge clk);
    check(stallCode == 2'd0, "R5 last access issued", stallCode, 0);
    @(negedge clk);
    check(queueEmpty == 1'b1, "R3 queue drained", queueEmpty, 1);
    repeat (6) @(negedge clk);

    // store acknowledgements in sector mode
    setEntry(0, 32'h000, 1, 64); setEntry(1, 32'h020, 1, 32); setEntry(2, 32'h040, 0, 32);
    doLoad(3);
    check(ackInc == 11'd3, "R9 sector store ack", ackInc, 3);
    repeat (6) @(negedge clk);

    // reservation fail holds bank1 head; a second request waits behind it
    lkRes = 8'b00_00_11_00;
    setEntry(0, 32'h3A0, 0, 32);
    doLoad(1);
    repeat (3) @(negedge clk);
    check(lookupValid[1] == 1'b1 && lookupAddr[63:32] == 32'h3A0, "R7 held head", lookupAddr[63:32], 32'h3A0);
    check(retire[1] == 1'b0, "R7 no retire on fail", retire[1], 0);
    @(negedge clk);
    setEntry(0, 32'h0A0, 0, 32);
    doLoad(1);
    check(lookupAddr[63:32] == 32'h3A0, "R7 still held", lookupAddr[63:32], 32'h3A0);
    repeat (2) @(negedge clk);
    check(lookupValid[1] == 1'b1 && lookupAddr[63:32] == 32'h3A0, "R7 held head", lookupAddr[63:32], 32'h3A0);
    @(posedge clk);
    #1 lkRes = '0;
    @(negedge clk);
    check(retire[1] == 1'b1, "R7 retire on hit", retire[1], 1);
    @(negedge clk);
    check(lookupValid[1] == 1'b1 && lookupAddr[63:32] == 32'h0A0, "R8 follower advances", lookupAddr[63:32], 32'h0A0);
    repeat (4) @(negedge clk);

    // line mode instance
    setLine(0, 32'h000, 1, 64); setLine(1, 32'h020, 0, 32);
    doLoadLine(2);
    check(lnStall == 2'd1, "R2 same line same bank", lnStall, 1);
    check(lnAck == '0, "R9 line load", lnAck, 0);
    @(negedge clk);
    check(lnValid == 2'b01 && lnAddr[31:0] == 32'h020, "R6 latency one", lnAddr[31:0], 32'h020);
    check(lnStall == 2'd1, "R4 tail busy while head retires", lnStall, 1);
    @(negedge clk);
    check(lnStall == 2'd0, "R4 retry issues", lnStall, 0);
    check(lnAck == 10'd1, "R9 line store ack", lnAck, 1);
    @(negedge clk);
    check(lnEmpty == 1'b1 && lnValid[0] == 1'b1 && lnAddr[31:0] == 32'h000, "R3 second access at head", lnAddr[31:0], 0);
    repeat (2) @(negedge clk);
    setLine(0, 32'h080, 0, 32); setLine(1, 32'h000, 0, 32);
    lnLoadStore = '0;
    doLoadLine(2);
    check(lnStall == 2'd0, "R2 different lines", lnStall, 0);
    @(negedge clk);
    check(lnValid == 2'b11, "R2 R6 both banks at head", lnValid, 3);
    repeat (4) @(negedge clk);

    for (int b = 0; b < 4; b++)
      check(expQ[b].size() == 0, "R7 all requests retired", expQ[b].size(), 0);
    finishRun();
  end

endmodule